// File: doc/BRIEF.md
# Radio Transceiver SPI Sequencer

This block controls an external packet radio through a four-wire SPI bus: an active-low select, a serial clock, a data line out and a data line in. It has three jobs. Each is started by its own one-cycle request input. A setup run writes a fixed list of register values held in an internal table. A send run pushes one packet into the radio's transmit buffer and then issues the transmit command. A fetch run reads one packet out of the radio's receive buffer. Each job ends with a one-cycle pulse on its own completion output, together with a pass/fail flag.

The bus runs in mode 0: the serial clock idles low, outgoing bits change after a falling edge and incoming bits are sampled on a rising edge. The serial clock period is `2*HALF` system cycles, so the default `HALF=10` at 200 MHz gives 10 MHz. Each transaction starts with one address or command byte. The byte the radio shifts back during that first byte is its status, and it is kept on `status`. One packet is `PKT_BITS` bits, 500 by default. On the bus it is carried as `PKT_BYTES = ceil(PKT_BITS/8)` bytes, most significant bit first, with zero pad bits at the tail.

The controller is one state machine. Its states are IDLE, SETUP, GO, WAIT, GAP and FIN, and they drive a byte shifter.
- IDLE→SETUP: when any request is accepted.
- SETUP→GO: after HALF cycles with select low.
- GO→WAIT: this always follows, because GO launches one byte.
- WAIT→GO: when a byte ends and more bytes remain in the transaction.
- WAIT→GAP: when the last byte of the transaction ends.
- GAP→SETUP: after 2*HALF cycles with select high, if more transactions remain.
- GAP→FIN: after the same 2*HALF cycles, when the job is complete.
- FIN→IDLE: always, after the one cycle in which FIN raises the done output and the flag.

Top module: `radio_spi_seq`

## Requirements
- R1: After reset `spi_cs_n`=1, `spi_sclk`=0, all three done outputs are 0 and `status`=0.
- R2: The bus uses SPI mode 0. The serial clock idles low. Data out is most significant bit first and is stable at each rising edge. Data in is sampled on the rising edge. The serial clock period inside a byte is exactly 2*HALF system cycles.
- R3: `spi_cs_n` stays low across every byte of a transaction. Between transactions it stays high for at least one serial clock period. `spi_sclk` never rises while `spi_cs_n` is high.
- R4: A setup run issues ROM_DEPTH transactions of 24 bits each, for entries k = 0, 1, 2 and so on in that order. Each entry is the byte 0x10+k followed by the 16-bit value 0x5A00 + k*0x0103.
- R5: A send run issues two transactions. The first is the byte 0x3E followed by `tx_pkt` in PKT_BYTES bytes, most significant bit first, zero-padded at the end. The second is the single command byte 0x09.
- R6: A fetch run issues one transaction: the byte 0x7F followed by PKT_BYTES bytes of 0x00. The bits returned after the first byte, most significant first with the pad dropped, appear on `rx_pkt`. They hold from `done_rx` until the next accepted request.
- R7: The byte returned on `spi_miso` during the first byte of each transaction appears on `status` once that byte ends.
- R8: Each run produces exactly one one-cycle pulse, on its own done output only. During that pulse `op_ok` equals bit 6 of the status byte from the run's final transaction.
- R9: A request that arrives while a run is in progress is ignored. It adds no transaction and no done pulse.
- R10: When several requests arrive together while idle, setup wins over send and send wins over fetch. The losing requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| begin_cfg | input | 1 | start a setup run (one-cycle pulse) |
| begin_tx | input | 1 | start a send run (one-cycle pulse) |
| begin_rx | input | 1 | start a fetch run (one-cycle pulse) |
| tx_pkt | input | PKT_BITS | packet to send, captured when the send request is accepted |
| done_cfg | output | 1 | setup run finished |
| done_tx | output | 1 | send run finished |
| done_rx | output | 1 | fetch run finished |
| op_ok | output | 1 | pass flag, valid while a done output is high |
| status | output | 8 | last status byte returned by the radio |
| rx_pkt | output | PKT_BITS | last fetched packet |
| spi_cs_n | output | 1 | active-low chip select |
| spi_sclk | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data to the radio |
| spi_miso | input | 1 | serial data from the radio |

## Verification
A bus model records every bit clocked out between select edges and answers with a chosen status byte and payload. The setup run is compared entry by entry against the arithmetic table, which tells apart wrong order, wrong framing and wrong byte splitting. Send runs use all-zero, all-one, single-bit and mixed packets with status bytes that alternate bit 6, which separates pad placement, bit order and the source of the flag. Fetch runs return complementary and striped payloads to test capture on the rising edge. Requests given during a run, and requests given together, check the ignore and priority rules.

// File: rtl/rss_pkg.sv
`timescale 1ns/1ps
package rss_pkg;

    typedef enum logic [1:0] {MODE_CFG, MODE_TX, MODE_RX} mode_e;

    typedef enum logic [2:0] {S_IDLE, S_SETUP, S_GO, S_WAIT, S_GAP, S_FIN} state_e;

    localparam logic [7:0] TXBUF_HDR  = 8'h3E;
    localparam logic [7:0] RXBUF_HDR  = 8'h7F;
    localparam logic [7:0] SEND_CMD   = 8'h09;
    localparam int         OK_BIT     = 6;

    function automatic logic [23:0] cfg_entry(input int k);
        logic [7:0]  a;
        logic [15:0] d;
        a = 8'(8'h10 + k);
        d = 16'(16'h5A00 + k * 16'h0103);
        return {a, d};
    endfunction

endpackage

// File: rtl/rss_cfg_rom.sv
`timescale 1ns/1ps
module rss_cfg_rom #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic [AW-1:0] addr,
    output logic [23:0]   word
);
    logic [23:0] rom_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign rom_arr[g] = rss_pkg::cfg_entry(g);
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < DEPTH; i++)
            if (32'(addr) == i) word = rom_arr[i];
    end
endmodule

// File: rtl/rss_byte_engine.sv
`timescale 1ns/1ps
module rss_byte_engine #(
    parameter int HALF = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

    logic          busy_q, sclk_q, done_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q, rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    sh_q   <= tx_byte;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DW'(HALF - 1)) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

    // R2: the serial clock rests low whenever no byte is in flight
    a_r2_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);

    // R2: outgoing bit does not move while the serial clock is high
    a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(sh_q[7]));
endmodule

// File: rtl/radio_spi_seq.sv
`timescale 1ns/1ps
module radio_spi_seq
    import rss_pkg::*;
#(
    parameter int PKT_BITS  = 500,
    parameter int ROM_DEPTH = 8,
    parameter int HALF      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                begin_cfg,
    input  logic                begin_tx,
    input  logic                begin_rx,
    input  logic [PKT_BITS-1:0] tx_pkt,
    output logic                done_cfg,
    output logic                done_tx,
    output logic                done_rx,
    output logic                op_ok,
    output logic [7:0]          status,
    output logic [PKT_BITS-1:0] rx_pkt,
    output logic                spi_cs_n,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int PKT_BYTES = (PKT_BITS + 7) / 8;
    localparam int PAD_W     = PKT_BYTES * 8;
    localparam int PAD       = PAD_W - PKT_BITS;
    localparam int IDX_W     = (ROM_DEPTH > 2) ? $clog2(ROM_DEPTH) : 1;
    localparam int BI_W      = $clog2(PKT_BYTES + 2);
    localparam int CNT_W     = $clog2(2 * HALF + 1);

    state_e             state_q, state_d;
    mode_e              mode_q, mode_sel;
    logic [IDX_W-1:0]   idx_q;
    logic [BI_W-1:0]    bidx_q, last_bidx;
    logic [CNT_W-1:0]   cnt_q;
    logic [PAD_W-1:0]   pay_q;
    logic [7:0]         status_q, byte_out, byte_in;
    logic [23:0]        rom_word;
    logic               byte_go, byte_done, any_begin, last_xact;

    rss_cfg_rom #(.DEPTH(ROM_DEPTH), .AW(IDX_W)) u_rom (
        .addr (idx_q),
        .word (rom_word)
    );

    rss_byte_engine #(.HALF(HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (byte_go),
        .tx_byte (byte_out),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (byte_done),
        .rx_byte (byte_in)
    );

    assign any_begin = begin_cfg | begin_tx | begin_rx;

    // R10: setup over send over fetch
    always_comb begin
        if (begin_cfg)     mode_sel = MODE_CFG;
        else if (begin_tx) mode_sel = MODE_TX;
        else               mode_sel = MODE_RX;
    end

    always_comb begin
        case (mode_q)
            MODE_CFG: begin
                last_bidx = BI_W'(2);
                last_xact = (idx_q == IDX_W'(ROM_DEPTH - 1));
                case (bidx_q)
                    BI_W'(0): byte_out = rom_word[23:16];
                    BI_W'(1): byte_out = rom_word[15:8];
                    default:  byte_out = rom_word[7:0];
                endcase
            end
            MODE_TX: begin
                last_bidx = (idx_q == '0) ? BI_W'(PKT_BYTES) : '0;
                last_xact = (idx_q == IDX_W'(1));
                if (idx_q != '0)       byte_out = SEND_CMD;
                else if (bidx_q == '0) byte_out = TXBUF_HDR;
                else                   byte_out = pay_q[PAD_W-1 -: 8];
            end
            default: begin
                last_bidx = BI_W'(PKT_BYTES);
                last_xact = 1'b1;
                byte_out  = (bidx_q == '0) ? RXBUF_HDR : 8'h00;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (any_begin) state_d = S_SETUP;
            S_SETUP: if (cnt_q == CNT_W'(HALF - 1)) state_d = S_GO;
            S_GO:    state_d = S_WAIT;
            S_WAIT:  if (byte_done) state_d = (bidx_q == last_bidx) ? S_GAP : S_GO;
            S_GAP:   if (cnt_q == CNT_W'(2 * HALF - 1)) state_d = last_xact ? S_FIN : S_SETUP;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_CFG;
            idx_q    <= '0;
            bidx_q   <= '0;
            cnt_q    <= '0;
            pay_q    <= '0;
            status_q <= '0;
        end else begin
            cnt_q <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == S_IDLE && any_begin) begin
                mode_q <= mode_sel;
                idx_q  <= '0;
                bidx_q <= '0;
                if (mode_sel == MODE_TX) pay_q <= PAD_W'(tx_pkt) << PAD;
            end
            if (state_q == S_WAIT && byte_done) begin
                bidx_q <= bidx_q + 1'b1;
                if (bidx_q == '0)          status_q <= byte_in;
                else if (mode_q == MODE_TX) pay_q   <= pay_q << 8;
                else if (mode_q == MODE_RX) pay_q   <= {pay_q[PAD_W-9:0], byte_in};
            end
            if (state_q == S_GAP && state_d == S_SETUP) begin
                idx_q  <= idx_q + 1'b1;
                bidx_q <= '0;
            end
        end
    end

    always_comb begin
        spi_cs_n = (state_q == S_IDLE) || (state_q == S_GAP) || (state_q == S_FIN);
        byte_go  = (state_q == S_GO);
        done_cfg = (state_q == S_FIN) && (mode_q == MODE_CFG);
        done_tx  = (state_q == S_FIN) && (mode_q == MODE_TX);
        done_rx  = (state_q == S_FIN) && (mode_q == MODE_RX);
        op_ok    = (state_q == S_FIN) && status_q[OK_BIT];
        status   = status_q;
        rx_pkt   = pay_q[PAD_W-1 -: PKT_BITS];
    end

    // checker state for the select gap window
    logic [CNT_W-1:0] hi_cnt_q;
    logic             seen_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q   <= '0;
            seen_low_q <= 1'b0;
        end else begin
            seen_low_q <= seen_low_q | !spi_cs_n;
            if (!spi_cs_n)                          hi_cnt_q <= '0;
            else if (hi_cnt_q != CNT_W'(2 * HALF))  hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    // R3: select high for a full serial clock period between transactions
    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && seen_low_q) |-> (hi_cnt_q == CNT_W'(2 * HALF)));

    // R3: no clock activity with select released
    a_r3_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R8: at most one done output at a time
    a_r8_one_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_cfg, done_tx, done_rx}));

    // R9: the running job cannot be replaced mid-run
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(mode_q));

    // R8: a done pulse lasts one cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cfg || done_tx || done_rx) |=> !(done_cfg || done_tx || done_rx));
endmodule

// File: tb/sim_radio_spi_seq.sv
`timescale 1ns/1ps
module sim_radio_spi_seq;
    localparam int PB   = 20;
    localparam int HALF = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          begin_cfg = 1'b0, begin_tx = 1'b0, begin_rx = 1'b0;
    logic [PB-1:0] tx_pkt = '0;
    logic          done_cfg, done_tx, done_rx, op_ok;
    logic [7:0]    status;
    logic [PB-1:0] rx_pkt;
    logic          spi_cs_n, spi_sclk, spi_mosi;
    logic          spi_miso = 1'b0;

    radio_spi_seq #(.PKT_BITS(PB), .ROM_DEPTH(8), .HALF(HALF)) u0 (.*);

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus model
    logic [7:0]  slv_status = 8'h40;
    logic [23:0] slv_data   = '0;
    int          bp = 0;
    logic [63:0] xbits [16];
    int          xlen  [16];
    int          xcount = 0;
    int          bad_edges = 0;
    time         t_hi = 0, t_rise = 0, min_gap = 1000000, min_per = 1000000;
    bit          have_hi = 0, have_rise = 0;

    always @(negedge spi_cs_n) begin
        bp = 0;
        spi_miso = slv_status[7];
        have_rise = 0;
        if (have_hi && ($time - t_hi) < min_gap) min_gap = $time - t_hi;
    end
    always @(posedge spi_cs_n) begin
        if (xcount < 15) xcount++;
        t_hi = $time;
        have_hi = 1;
    end
    always @(posedge spi_sclk) begin
        if (spi_cs_n) bad_edges++;
        else if (xcount < 16) begin
            xbits[xcount] = {xbits[xcount][62:0], spi_mosi};
            xlen[xcount]++;
        end
        if (have_rise && ($time - t_rise) < min_per) min_per = $time - t_rise;
        t_rise = $time;
        have_rise = 1;
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            logic [31:0] s;
            s = {slv_status, slv_data};
            bp++;
            spi_miso = (bp < 32) ? s[31 - bp] : 1'b0;
        end
    end

    int  n_cfg = 0, n_tx = 0, n_rx = 0;
    bit  ok_seen = 0;
    always @(posedge clk) begin
        if (done_cfg) n_cfg++;
        if (done_tx)  n_tx++;
        if (done_rx)  n_rx++;
        if (done_cfg || done_tx || done_rx) ok_seen = op_ok;
    end

    task automatic clear_rec();
        for (int i = 0; i < 16; i++) begin xbits[i] = '0; xlen[i] = 0; end
        xcount = 0;
        have_hi = 0;
        n_cfg = 0; n_tx = 0; n_rx = 0;
    endtask

    task automatic pulse(input bit c, input bit t, input bit r);
        @(negedge clk);
        begin_cfg = c; begin_tx = t; begin_rx = r;
        @(negedge clk);
        begin_cfg = 0; begin_tx = 0; begin_rx = 0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while ((n_cfg + n_tx + n_rx) == 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 20000, req, 64'(n), 64'd20000);
        repeat (300) @(negedge clk);
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [PB-1:0] pats [4];
        logic [23:0]   rpats [4];
        logic [7:0]    sts [4];
        pats[0] = 20'h00000; pats[1] = 20'hFFFFF; pats[2] = 20'h00001; pats[3] = 20'hA5C3F;
        rpats[0] = 24'hA5F00F; rpats[1] = 24'h5A0FF0; rpats[2] = 24'hFFFFFF; rpats[3] = 24'h00000F;
        sts[0] = 8'h40; sts[1] = 8'hBF; sts[2] = 8'hFF; sts[3] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n === 1'b1, "R1 cs_n", 64'(spi_cs_n), 64'd1);
        chk(spi_sclk === 1'b0, "R1 sclk", 64'(spi_sclk), 64'd0);
        chk({done_cfg, done_tx, done_rx} === 3'b000, "R1 done", 64'({done_cfg, done_tx, done_rx}), 64'd0);
        chk(status === 8'h00, "R1 status", 64'(status), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 setup run, R7 status, R8 flag
        clear_rec();
        slv_status = 8'h4C;
        pulse(1, 0, 0);
        wait_done("R4 setup completes");
        chk(xcount == 8, "R4 transaction count", 64'(xcount), 64'd8);
        for (int k = 0; k < 8; k++) begin
            logic [23:0] e;
            e = {8'(16 + k), 16'(16'h5A00 + k * 16'h0103)};
            chk(xlen[k] == 24 && xbits[k][23:0] == e, "R4 entry", xbits[k], 64'(e));
        end
        chk(n_cfg == 1 && n_tx == 0 && n_rx == 0, "R8 one setup done", 64'(n_cfg), 64'd1);
        chk(ok_seen == 1'b1, "R8 flag bit6 set", 64'(ok_seen), 64'd1);
        chk(status == 8'h4C, "R7 status byte", 64'(status), 64'h4C);

        // R5 send runs
        for (int p = 0; p < 4; p++) begin
            clear_rec();
            slv_status = sts[p];
            tx_pkt = pats[p];
            pulse(0, 1, 0);
            wait_done("R5 send completes");
            chk(xcount == 2, "R5 transaction count", 64'(xcount), 64'd2);
            chk(xlen[0] == 32 && xbits[0][31:0] == {8'h3E, pats[p], 4'h0}, "R5 buffer write", xbits[0], 64'({8'h3E, pats[p], 4'h0}));
            chk(xlen[1] == 8 && xbits[1][7:0] == 8'h09, "R5 command byte", xbits[1], 64'h09);
            chk(ok_seen == sts[p][6], "R8 send flag", 64'(ok_seen), 64'(sts[p][6]));
            chk(n_tx == 1 && n_cfg == 0 && n_rx == 0, "R8 one send done", 64'(n_tx), 64'd1);
            chk(status == sts[p], "R7 status after send", 64'(status), 64'(sts[p]));
        end

        // R6 fetch runs
        for (int p = 0; p < 4; p++) begin
            clear_rec();
            slv_status = sts[3 - p];
            slv_data = rpats[p];
            pulse(0, 0, 1);
            wait_done("R6 fetch completes");
            chk(xcount == 1 && xlen[0] == 32 && xbits[0][31:0] == 64'h7F000000, "R6 fetch frame", xbits[0], 64'h7F000000);
            chk(rx_pkt == rpats[p][23:4], "R6 rx packet", 64'(rx_pkt), 64'(rpats[p][23:4]));
            chk(n_rx == 1 && ok_seen == sts[3 - p][6], "R8 fetch flag", 64'(ok_seen), 64'(sts[3 - p][6]));
        end

        // R9 requests while busy are ignored
        clear_rec();
        pulse(1, 0, 0);
        repeat (300) @(negedge clk);
        pulse(0, 1, 1);
        wait_done("R9 setup completes");
        chk(xcount == 8, "R9 no extra transactions", 64'(xcount), 64'd8);
        chk(n_tx == 0 && n_rx == 0 && n_cfg == 1, "R9 no extra done", 64'(n_tx + n_rx), 64'd0);
        chk(rx_pkt == rpats[3][23:4], "R9 rx packet untouched", 64'(rx_pkt), 64'(rpats[3][23:4]));

        // R10 priority
        clear_rec();
        pulse(1, 0, 1);
        wait_done("R10 setup wins");
        chk(xcount == 8 && n_cfg == 1 && n_rx == 0, "R10 setup over fetch", 64'(xcount), 64'd8);
        clear_rec();
        tx_pkt = 20'h13579;
        pulse(0, 1, 1);
        wait_done("R10 send wins");
        chk(xcount == 2 && n_tx == 1 && n_rx == 0, "R10 send over fetch", 64'(xcount), 64'd2);
        chk(xbits[0][31:0] == {8'h3E, 20'h13579, 4'h0}, "R10 send frame", xbits[0], 64'({8'h3E, 20'h13579, 4'h0}));

        // R2 / R3 timing
        chk(min_per == 100, "R2 sclk period", 64'(min_per), 64'd100);
        chk(min_gap >= 100, "R3 select gap", 64'(min_gap), 64'd100);
        chk(bad_edges == 0, "R3 sclk with select high", 64'(bad_edges), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule